// File: doc/BRIEF.md
# Adaptive Black Level Expander

This block is a streaming luma enhancer that deepens the dark end of the picture, one sample per clock. While a field streams through, a four-sample moving average of the valid luma is tracked for its smallest and largest value. Only samples on lines inside a programmable vertical window are tracked. At the next field start those two values are frozen and used for the whole following field.

From the frozen range and a fractional tilt coefficient the block derives a tilt point. Samples below the tilt point are pushed further toward black by a programmable fraction of their distance to it. All other samples leave unchanged. A separate ceiling disables expansion for samples brighter than it.

Because the tilt point follows the measured range, a picture with little dynamic range gets a tilt point close to its own minimum. Expansion then fades out without intervention from software.

Top module: `black_level_expander`

## Requirements
- R1: `valid_o` equals `valid_i` delayed by exactly 3 clocks. `luma_o` is the processed form of the `luma_i` sample presented 3 clocks earlier.
- R2: The statistics are taken from a filtered value. This value is floor((current sample + previous three valid samples) / 4). The history shifts only on `valid_i`, starts at zero after reset, and is not cleared by line or field pulses.
- R3: A line count is zeroed by `field_start_i` and advanced by each `line_start_i`. A valid sample is tracked only if the count held in its cycle lies in [`win_first_i`, `win_last_i`] inclusive. A sample in a `field_start_i` cycle is never tracked.
- R4: On `field_start_i` the tracked minimum and maximum become the field statistics, and tracking restarts. The field statistics apply to samples from the next cycle onward. They are 0/0 after reset and after a field in which no sample was tracked.
- R5: The tilt point is Lt = min + floor(tilt_coef × (max − min) / 16), with `tilt_coef_i` an unsigned fraction in sixteenths. When max equals min, Lt equals min.
- R6: A sample with Lin < Lt and Lin ≤ ceiling leaves as Lin − floor(gain × (Lt − Lin) / 16), clamped at 0, with `gain_i` in sixteenths.
- R7: A sample with Lin ≥ Lt leaves unchanged.
- R8: A sample with Lin > `ceil_i` leaves unchanged whatever the tilt point.
- R9: `tilt_coef_i`, `gain_i` and `ceil_i` are taken in the same cycle as the sample they act on, so a change applies exactly from that sample onward.
- R10: During reset `valid_o` and `luma_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| luma_i | input | 8 | Input luma |
| line_start_i | input | 1 | One-cycle pulse at each line start |
| field_start_i | input | 1 | One-cycle pulse at each field start |
| win_first_i | input | 10 | First tracked line |
| win_last_i | input | 10 | Last tracked line |
| tilt_coef_i | input | 4 | Tilt coefficient, sixteenths |
| gain_i | input | 4 | Expansion amount, sixteenths |
| ceil_i | input | 8 | Brightest luma still expanded |
| valid_o | output | 1 | Output sample strobe |
| luma_o | output | 8 | Expanded luma |

## Verification
The hardest cases to reach from the ports come from the one-field lag of the statistics. A field whose window catches no sample only shows its effect one field later. So does a sample that arrives together with the field pulse: it still enters the filter history, yet it must not be tracked.

The stimulus therefore runs sequences of fields:
- a window placed beyond the last line;
- a field pulse carrying a black sample while the window starts at line 0;
- a bright single-line window whose first filtered values still mix in the dark tail of the previous line.

Coefficients change both between fields and on every sample, so the gain sampled with each pixel is seen separately.

// File: rtl/blx_pkg.sv
`timescale 1ns/1ps
package blx_pkg;
  localparam int unsigned BLX_DATA_W    = 8;
  localparam int unsigned BLX_FRAC_W    = 4;
  localparam int unsigned BLX_LINE_W    = 10;
  localparam int unsigned BLX_TAPS_LOG2 = 2;

  // per-sample decision carried from stage 2 to stage 3
  typedef enum logic [1:0] {
    SEL_PASS_TILT = 2'd0,
    SEL_PASS_CEIL = 2'd1,
    SEL_EXPAND    = 2'd2
  } blx_sel_e;
endpackage

// File: rtl/blx_lpf.sv
`timescale 1ns/1ps
module blx_lpf #(
  parameter int unsigned DATA_W    = blx_pkg::BLX_DATA_W,
  parameter int unsigned TAPS_LOG2 = blx_pkg::BLX_TAPS_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] luma_i,
  output logic [DATA_W-1:0] avg_o
);
  localparam int unsigned TAPS  = 1 << TAPS_LOG2;
  localparam int unsigned SUM_W = DATA_W + TAPS_LOG2;

  logic [TAPS-2:0][DATA_W-1:0] hist_q;
  logic [SUM_W-1:0]            sum;

  if (TAPS > 2) begin : g_deep
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hist_q <= '0;
      else if (valid_i) hist_q <= {hist_q[TAPS-3:0], luma_i};
    end
  end else begin : g_single
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      hist_q <= '0;
      else if (valid_i) hist_q <= luma_i;
    end
  end

  always_comb begin
    sum = SUM_W'(luma_i);
    for (int i = 0; i < TAPS - 1; i++) sum = sum + SUM_W'(hist_q[i]);
  end

  assign avg_o = DATA_W'(sum >> TAPS_LOG2);
endmodule

// File: rtl/blx_stats.sv
`timescale 1ns/1ps
module blx_stats #(
  parameter int unsigned DATA_W = blx_pkg::BLX_DATA_W,
  parameter int unsigned LINE_W = blx_pkg::BLX_LINE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] avg_i,
  input  logic              line_start_i,
  input  logic              field_start_i,
  input  logic [LINE_W-1:0] win_first_i,
  input  logic [LINE_W-1:0] win_last_i,
  output logic [DATA_W-1:0] field_min_o,
  output logic [DATA_W-1:0] field_max_o
);
  localparam logic [LINE_W-1:0] LINE_MAX = '1;

  logic [LINE_W-1:0] line_q;
  logic [DATA_W-1:0] run_min_q, run_max_q;
  logic [DATA_W-1:0] fmin_q, fmax_q;
  logic              in_win;
  logic              empty_run;

  assign in_win = valid_i && !field_start_i &&
                  (line_q >= win_first_i) && (line_q <= win_last_i);
  // nothing tracked leaves min above max
  assign empty_run = run_max_q < run_min_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                line_q <= '0;
    else if (field_start_i)                     line_q <= '0;
    else if (line_start_i && line_q != LINE_MAX) line_q <= line_q + LINE_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_min_q <= '1;
      run_max_q <= '0;
    end else if (field_start_i) begin
      run_min_q <= '1;
      run_max_q <= '0;
    end else if (in_win) begin
      if (avg_i < run_min_q) run_min_q <= avg_i;
      if (avg_i > run_max_q) run_max_q <= avg_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fmin_q <= '0;
      fmax_q <= '0;
    end else if (field_start_i) begin
      fmin_q <= empty_run ? '0 : run_min_q;
      fmax_q <= empty_run ? '0 : run_max_q;
    end
  end

  assign field_min_o = fmin_q;
  assign field_max_o = fmax_q;
endmodule

// File: rtl/blx_tilt.sv
`timescale 1ns/1ps
module blx_tilt #(
  parameter int unsigned DATA_W = blx_pkg::BLX_DATA_W,
  parameter int unsigned FRAC_W = blx_pkg::BLX_FRAC_W
) (
  input  logic [DATA_W-1:0] field_min_i,
  input  logic [DATA_W-1:0] field_max_i,
  input  logic [FRAC_W-1:0] coef_i,
  output logic [DATA_W-1:0] tilt_o
);
  localparam int unsigned PW = DATA_W + FRAC_W;

  logic [DATA_W-1:0] span;
  logic [PW-1:0]     prod;

  assign span   = field_max_i - field_min_i;
  assign prod   = PW'(span) * PW'(coef_i);
  assign tilt_o = field_min_i + DATA_W'(prod >> FRAC_W);
endmodule

// File: rtl/blx_expand.sv
`timescale 1ns/1ps
module blx_expand
  import blx_pkg::*;
#(
  parameter int unsigned DATA_W = BLX_DATA_W,
  parameter int unsigned FRAC_W = BLX_FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] luma_i,
  input  logic [DATA_W-1:0] tilt_i,
  input  logic [FRAC_W-1:0] gain_i,
  input  logic [DATA_W-1:0] ceil_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] luma_o
);
  localparam int unsigned PW = DATA_W + FRAC_W;

  // stage 1: capture sample with its coefficients
  logic              vld1_q;
  logic [DATA_W-1:0] pix1_q, tilt1_q, ceil1_q;
  logic [FRAC_W-1:0] gain1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld1_q  <= 1'b0;
      pix1_q  <= '0;
      tilt1_q <= '0;
      ceil1_q <= '0;
      gain1_q <= '0;
    end else begin
      vld1_q  <= valid_i;
      pix1_q  <= luma_i;
      tilt1_q <= tilt_i;
      ceil1_q <= ceil_i;
      gain1_q <= gain_i;
    end
  end

  // stage 2: classify and scale the distance to the tilt point
  blx_sel_e          sel1;
  logic [DATA_W-1:0] gap1;
  logic [PW-1:0]     prod1;
  logic [DATA_W-1:0] dlt1;

  always_comb begin
    if (pix1_q > ceil1_q)       sel1 = SEL_PASS_CEIL;
    else if (pix1_q >= tilt1_q) sel1 = SEL_PASS_TILT;
    else                        sel1 = SEL_EXPAND;
  end

  assign gap1  = tilt1_q - pix1_q;
  assign prod1 = PW'(gap1) * PW'(gain1_q);
  assign dlt1  = (sel1 == SEL_EXPAND) ? DATA_W'(prod1 >> FRAC_W) : '0;

  logic              vld2_q;
  logic [DATA_W-1:0] pix2_q, dlt2_q;
  blx_sel_e          sel2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld2_q <= 1'b0;
      pix2_q <= '0;
      dlt2_q <= '0;
      sel2_q <= SEL_PASS_TILT;
    end else begin
      vld2_q <= vld1_q;
      pix2_q <= pix1_q;
      dlt2_q <= dlt1;
      sel2_q <= sel1;
    end
  end

  // stage 3: subtract, clamp at black
  logic [DATA_W-1:0] res2;

  always_comb begin
    if (sel2_q == SEL_EXPAND) res2 = (pix2_q >= dlt2_q) ? pix2_q - dlt2_q : '0;
    else                      res2 = pix2_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      luma_o  <= '0;
    end else begin
      valid_o <= vld2_q;
      luma_o  <= res2;
    end
  end
endmodule

// File: rtl/black_level_expander.sv
`timescale 1ns/1ps
module black_level_expander #(
  parameter int unsigned DATA_W    = blx_pkg::BLX_DATA_W,
  parameter int unsigned FRAC_W    = blx_pkg::BLX_FRAC_W,
  parameter int unsigned LINE_W    = blx_pkg::BLX_LINE_W,
  parameter int unsigned TAPS_LOG2 = blx_pkg::BLX_TAPS_LOG2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] luma_i,
  input  logic              line_start_i,
  input  logic              field_start_i,
  input  logic [LINE_W-1:0] win_first_i,
  input  logic [LINE_W-1:0] win_last_i,
  input  logic [FRAC_W-1:0] tilt_coef_i,
  input  logic [FRAC_W-1:0] gain_i,
  input  logic [DATA_W-1:0] ceil_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] luma_o
);
  logic [DATA_W-1:0] avg_w;
  logic [DATA_W-1:0] fmin_w, fmax_w;
  logic [DATA_W-1:0] tilt_w;

  blx_lpf #(.DATA_W(DATA_W), .TAPS_LOG2(TAPS_LOG2)) u_lpf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .luma_i  (luma_i),
    .avg_o   (avg_w)
  );

  blx_stats #(.DATA_W(DATA_W), .LINE_W(LINE_W)) u_stats (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .valid_i       (valid_i),
    .avg_i         (avg_w),
    .line_start_i  (line_start_i),
    .field_start_i (field_start_i),
    .win_first_i   (win_first_i),
    .win_last_i    (win_last_i),
    .field_min_o   (fmin_w),
    .field_max_o   (fmax_w)
  );

  blx_tilt #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_tilt (
    .field_min_i (fmin_w),
    .field_max_i (fmax_w),
    .coef_i      (tilt_coef_i),
    .tilt_o      (tilt_w)
  );

  blx_expand #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_expand (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .luma_i  (luma_i),
    .tilt_i  (tilt_w),
    .gain_i  (gain_i),
    .ceil_i  (ceil_i),
    .valid_o (valid_o),
    .luma_o  (luma_o)
  );
endmodule

// File: rtl/black_level_expander_chk.sv
`timescale 1ns/1ps
module black_level_expander_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned FRAC_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] luma_i,
  input logic [FRAC_W-1:0] gain_i,
  input logic [DATA_W-1:0] ceil_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] luma_o,
  input logic [DATA_W-1:0] fmin,
  input logic [DATA_W-1:0] fmax,
  input logic [DATA_W-1:0] tilt
);
  a_r1_valid_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni, 3) |-> (valid_o == $past(valid_i, 3)));

  a_r6_never_brighter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 3) && valid_o) |-> (luma_o <= $past(luma_i, 3)));

  a_r6_zero_gain_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 3) && ($past(gain_i, 3) == '0)) |-> (luma_o == $past(luma_i, 3)));

  a_r8_above_ceiling: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 3) && ($past(luma_i, 3) > $past(ceil_i, 3))) |-> (luma_o == $past(luma_i, 3)));

  a_r4_range_ordered: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmin <= fmax);

  a_r5_tilt_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tilt >= fmin) && (tilt <= fmax));
endmodule

bind black_level_expander black_level_expander_chk #(.DATA_W(DATA_W), .FRAC_W(FRAC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .luma_i  (luma_i),
  .gain_i  (gain_i),
  .ceil_i  (ceil_i),
  .valid_o (valid_o),
  .luma_o  (luma_o),
  .fmin    (fmin_w),
  .fmax    (fmax_w),
  .tilt    (tilt_w)
);

// File: tb/black_level_expander_bench.sv
`timescale 1ns/1ps
module black_level_expander_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [7:0] luma_i = '0;
  logic       line_start_i = 1'b0;
  logic       field_start_i = 1'b0;
  logic [9:0] win_first_i = 10'd1;
  logic [9:0] win_last_i = 10'd3;
  logic [3:0] tilt_coef_i = 4'd8;
  logic [3:0] gain_i = 4'd8;
  logic [7:0] ceil_i = 8'd255;
  logic       valid_o;
  logic [7:0] luma_o;

  always #2.5 clk_i = ~clk_i;

  black_level_expander u_black_level_expander (
    .clk_i, .rst_ni, .valid_i, .luma_i, .line_start_i, .field_start_i,
    .win_first_i, .win_last_i, .tilt_coef_i, .gain_i, .ceil_i,
    .valid_o, .luma_o
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 0;
  string scen = "R10 reset";
  logic [31:0] seed = 32'h1234_5678;

  // behavioural reference state
  int    m_hist[$];
  int    m_line = 0, m_rmin = 255, m_rmax = 0, m_fmin = 0, m_fmax = 0;
  int    pv[3] = '{0, 0, 0};
  int    pl[3] = '{0, 0, 0};
  string pt[3] = '{"R1", "R1", "R1"};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s [%s]: actual %0d expected %0d", req, scen, act, exp);
    end
  endtask

  function automatic int gen(input int pat, input int ln, input int k);
    seed = seed * 32'd1103515245 + 32'd12345;
    case (pat)
      0: return (k * 10 + ln * 3) % 256;
      2: return 100;
      3: return (ln == 2) ? 200 : 20;
      default: return int'(seed[23:16]);
    endcase
  endfunction

  task automatic cycle(input bit v, input int p, input bit ls, input bit fs);
    int lt, o, a, d;
    string tg;
    valid_i = v; luma_i = 8'(p); line_start_i = ls; field_start_i = fs;
    // R5 tilt, R6/R7/R8 per-sample result with coefficients of this cycle (R9)
    lt = m_fmin + (int'(tilt_coef_i) * (m_fmax - m_fmin)) / 16;
    if (p > int'(ceil_i)) begin o = p; tg = "R8"; end
    else if (p >= lt)     begin o = p; tg = "R7"; end
    else begin
      d = (int'(gain_i) * (lt - p)) / 16;
      o = (p - d < 0) ? 0 : p - d;
      tg = "R6";
    end
    if (!v) tg = "R1";
    pv[2] = pv[1]; pl[2] = pl[1]; pt[2] = pt[1];
    pv[1] = pv[0]; pl[1] = pl[0]; pt[1] = pt[0];
    pv[0] = v;     pl[0] = o;     pt[0] = tg;
    // R2 filtered value, R3 window, R4 field latch
    a = p;
    for (int i = 0; i < 3; i++) a += m_hist[i];
    a = a / 4;
    if (fs) begin
      if (m_rmax < m_rmin) begin m_fmin = 0; m_fmax = 0; end
      else begin m_fmin = m_rmin; m_fmax = m_rmax; end
      m_rmin = 255; m_rmax = 0; m_line = 0;
    end else begin
      if (v && m_line >= int'(win_first_i) && m_line <= int'(win_last_i)) begin
        if (a < m_rmin) m_rmin = a;
        if (a > m_rmax) m_rmax = a;
      end
      if (ls) m_line++;
    end
    if (v) begin m_hist.push_front(p); void'(m_hist.pop_back()); end
    @(posedge clk_i);
    @(negedge clk_i);
    check("R1", int'(valid_o), pv[2]);
    if (pv[2] != 0) check(pt[2], int'(luma_o), pl[2]);
  endtask

  task automatic run_field(input int lines, input int ppl, input int pat, input bit hot);
    cycle(hot, 0, 0, 1);
    for (int ln = 1; ln <= lines; ln++) begin
      cycle(0, 0, 1, 0);
      for (int k = 0; k < ppl; k++) begin
        if (pat == 4) gain_i = 4'(k);
        cycle(1, gen(pat, ln, k), 0, 0);
      end
      cycle(0, 0, 0, 0);
      cycle(0, 0, 0, 0);
    end
  endtask

  initial begin
    m_hist = '{0, 0, 0};
    repeat (3) @(negedge clk_i);
    // R10 outputs held at zero in reset
    check("R10", int'(valid_o), 0);
    check("R10", int'(luma_o), 0);
    rst_ni = 1'b1;

    scen = "R4 reset stats pass through";  run_field(5, 24, 0, 0);
    scen = "R5 ramp stats";                 run_field(5, 24, 0, 0);
    scen = "R6 random";                     run_field(5, 24, 1, 0);
    tilt_coef_i = 4'd15; gain_i = 4'd15;
    scen = "R6 clamp at black";             run_field(5, 24, 1, 0);
    run_field(5, 24, 1, 0);
    ceil_i = 8'd40;
    scen = "R8 ceiling";                    run_field(5, 24, 1, 0);
    ceil_i = 8'd255; win_first_i = 10'd2; win_last_i = 10'd2;
    scen = "R3 single-line window";         run_field(5, 24, 3, 0);
    run_field(5, 24, 1, 0);
    win_first_i = 10'd50; win_last_i = 10'd60;
    scen = "R4 empty window";               run_field(5, 24, 1, 0);
    run_field(5, 24, 1, 0);
    win_first_i = 10'd0; win_last_i = 10'd4;
    scen = "R3 sample on field pulse";      run_field(4, 24, 2, 1);
    run_field(4, 24, 1, 1);
    scen = "R2 flat picture";               run_field(4, 24, 2, 0);
    tilt_coef_i = 4'd0; gain_i = 4'd12;
    run_field(4, 24, 1, 0);
    tilt_coef_i = 4'd10;
    scen = "R9 per-sample gain";            run_field(5, 32, 4, 0);
    run_field(5, 32, 4, 0);
    tilt_coef_i = 4'd6; gain_i = 4'd5;
    scen = "R7 mid tilt";                   run_field(5, 24, 1, 0);
    run_field(5, 24, 0, 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule